// File: doc/BRIEF.md
# Conversion Result Store with Slot Status and Interrupt Routing

This block holds the converted value for each of sixteen sample slots of an analog-to-digital converter. Each time a slot finishes a conversion, its result is stored and a per-slot valid flag is raised. If software has not yet collected the previous value, a per-slot overrun flag records the loss. Slots 0 to 3 can each be switched to a two-deep mode, in which a second result register takes a new value while the first is still unread.

Slot completions are also routed to four interrupt lines. Each line has a sixteen-bit slot mask, a sticky flag and an enable. A flag raised again while still set marks an interrupt overrun for that line. A set of summary bits tells software at a glance whether any valid data, any data overrun, any trigger overrun or any interrupt overrun is outstanding. A self-clearing soft reset clears all of this run-time state.

The register bus is reduced to single-cycle read and write strobes with a word address. Read data is combinational from the current state, and a read strobe applies its side effects at the clock edge.

Top module: `eocres_top`

## Requirements
- R1: A completion (`eocValid`) for slot s stores `eocData` in that slot's result word at address s and sets its valid flag. The word reads as data in bits 15:0, overrun in bit 16 and valid in bit 17, with the new value visible from the next cycle.
- R2: A completion for a slot whose single result is still valid replaces the data, keeps valid at 1 and sets the slot's overrun bit.
- R3: A read strobe on a result word returns the word as it was before the read, then clears that slot's valid bit and overrun bit; the stored data is kept.
- R4: Bit s of the two-deep mask at address 23 (s = 0..3) enables the second register of slot s, read at address 16+s as {valid 17, slot overrun 16, data 15:0}. A completion while the first is valid and the second is free fills the second without an overrun. With both full, the first is overwritten and overrun sets. Reading the second register clears only its own valid bit.
- R5: Mask bits for slots 4 and above cannot be set (address 23 reads them as 0), and those slots stay single-buffered.
- R6: The status word at address 20 shows the per-slot valid bits in 15:0 and the per-slot overrun bits in 31:16.
- R7: The slot mask of interrupt line n sits at address 24+n. A completion on a slot whose mask bit is 1 sets flag n (status word at address 21, bit n). Writing 1 to that bit clears it, and a set in the same cycle wins over the clear.
- R8: `intReq[n]` is 1 exactly when flag n is 1 and enable bit n+2 of the control word at address 22 is 1.
- R9: Setting flag n while it is already 1 sets interrupt-overrun bit 8+n at address 21. Writing 1 to that bit clears it.
- R10: At address 21, bit 27 is 1 while any slot overrun is set, bit 26 while any result (first or second register) is valid, bit 25 while any trigger-overrun bit is set, and bit 24 while any interrupt-overrun bit is set.
- R11: A pulse on `trgOvf[s]` sets bit s of the trigger-overrun word at address 28. Writing 1 to that bit clears it.
- R12: Writing 1 to bit 1 of address 22 starts a soft reset. Bit 1 then reads 1 for RST_CYCLES cycles and clears by itself. During that time all valid, overrun, flag and interrupt-overrun bits are held at 0 and completions are ignored. Result data, masks and enables are kept. After the hardware reset, every status and control word reads 0.
- R13: A completion and a read strobe on the same slot in the same cycle return the old word and leave the new data valid with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eocValid | input | 1 | End-of-conversion strobe |
| eocSlot | input | 4 | Slot that finished |
| eocData | input | 16 | Converted value |
| trgOvf | input | 16 | Per-slot trigger-overrun pulses |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write word address |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Register read strobe (side effects at clock edge) |
| rdAddr | input | 5 | Read word address |
| rdData | output | 32 | Read data, combinational from current state |
| intReq | output | 4 | Interrupt requests, one per line |

## Verification
Every stored effect of a completion, write, trigger pulse or read strobe lands at the first rising edge after the strobe is presented. It is therefore visible on `rdData` and `intReq` one cycle later. A read returns the pre-edge state in the same cycle it is presented. The bench drives every strobe on a falling edge and removes it on the next one. It observes results on the falling edge that follows the updating rising edge: during the strobe cycle for read return values, and afterwards for state. The soft-reset window is timed by counting falling edges from the write, so the control bit is checked while busy and again once the RST_CYCLES countdown has elapsed.

// File: rtl/eocres_pkg.sv
package eocres_pkg;
  localparam int SLOTS    = 16;
  localparam int DATA_W   = 16;
  localparam int LINES    = 4;
  localparam int DB_SLOTS = 4;
  localparam int ADDR_W   = 5;
  localparam int WR_W     = 16;
  localparam int RD_W     = 32;
  localparam int SLOT_W   = $clog2(SLOTS);

  // word addresses
  localparam int ADR_SEC   = SLOTS;
  localparam int ADR_STAT0 = ADR_SEC + DB_SLOTS;
  localparam int ADR_STAT1 = ADR_STAT0 + 1;
  localparam int ADR_CTRL  = ADR_STAT0 + 2;
  localparam int ADR_DBM   = ADR_STAT0 + 3;
  localparam int ADR_MASK  = ADR_STAT0 + 4;
  localparam int ADR_EVOVF = ADR_MASK + LINES;

  // status word 1 bit positions
  localparam int ST1_IOVF  = 8;
  localparam int ST1_ANYIO = 24;
  localparam int ST1_ANYEV = 25;
  localparam int ST1_ANYV  = 26;
  localparam int ST1_ANYOV = 27;
  localparam int CTRL_RST  = 1;
  localparam int CTRL_EN   = 2;

  typedef struct packed {
    logic                eocWe;
    logic [SLOT_W-1:0]   eocSlot;
    logic [DATA_W-1:0]   eocData;
    logic [SLOTS-1:0]    rdPri;
    logic [DB_SLOTS-1:0] rdSec;
    logic                clrAll;
    logic [DB_SLOTS-1:0] dbEn;
  } dpStrobe_t;
endpackage

// File: rtl/eocres_datapath.sv
module eocres_datapath
  import eocres_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strb,
  output logic [SLOTS-1:0]               priValid,
  output logic [SLOTS-1:0]               ovf,
  output logic [SLOTS-1:0][DATA_W-1:0]   priData,
  output logic [DB_SLOTS-1:0]            secValid,
  output logic [DB_SLOTS-1:0][DATA_W-1:0] secData
);

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic hit;
    logic vAfter;
    logic ovAfter;
    logic secFree;

    assign hit     = strb.eocWe && (strb.eocSlot == SLOT_W'(s));
    assign vAfter  = priValid[s] && !strb.rdPri[s];
    assign ovAfter = ovf[s] && !strb.rdPri[s];

    if (s < DB_SLOTS) begin : gDb
      logic              secV;
      logic [DATA_W-1:0] secD;
      assign secFree = strb.dbEn[s] && !(secV && !strb.rdSec[s]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          secV <= 1'b0;
          secD <= '0;
        end else if (strb.clrAll) begin
          secV <= 1'b0;
        end else if (hit && vAfter && secFree) begin
          secD <= strb.eocData;
          secV <= 1'b1;
        end else if (strb.rdSec[s]) begin
          secV <= 1'b0;
        end
      end

      assign secValid[s] = secV;
      assign secData[s]  = secD;

      AST_DB_SECOND_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
        (hit && !strb.clrAll && strb.dbEn[s] && priValid[s] && !strb.rdPri[s]
         && !secValid[s] && !ovf[s]) |=> (secValid[s] && !ovf[s])); // R4
    end else begin : gSingle
      assign secFree = 1'b0;

      AST_SINGLE_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
        (hit && !strb.clrAll && priValid[s] && !strb.rdPri[s]) |=> ovf[s]); // R2
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        priValid[s] <= 1'b0;
        ovf[s]      <= 1'b0;
        priData[s]  <= '0;
      end else if (strb.clrAll) begin
        priValid[s] <= 1'b0;
        ovf[s]      <= 1'b0;
      end else if (hit && !vAfter) begin
        priData[s]  <= strb.eocData;
        priValid[s] <= 1'b1;
        ovf[s]      <= ovAfter;
      end else if (hit && !secFree) begin
        priData[s]  <= strb.eocData;
        priValid[s] <= 1'b1;
        ovf[s]      <= 1'b1;
      end else begin
        priValid[s] <= vAfter;
        ovf[s]      <= ovAfter;
      end
    end

    AST_EOC_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !strb.clrAll) |=> priValid[s]); // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rdPri[s] && !hit) |=> (!priValid[s] && !ovf[s])); // R3
    AST_SAME_CYCLE_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rdPri[s] && hit && !strb.clrAll) |=> (priValid[s] && !ovf[s])); // R13
  end

endmodule

// File: rtl/eocres_ctrl.sv
module eocres_ctrl
  import eocres_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            eocIn,
  input  logic [SLOT_W-1:0]               eocSlotIn,
  input  logic [DATA_W-1:0]               eocDataIn,
  input  logic [SLOTS-1:0]                trgOvf,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [WR_W-1:0]                 wrData,
  input  logic                            rdEn,
  input  logic [ADDR_W-1:0]               rdAddr,
  input  logic [SLOTS-1:0]                priValid,
  input  logic [SLOTS-1:0]                ovf,
  input  logic [SLOTS-1:0][DATA_W-1:0]    priData,
  input  logic [DB_SLOTS-1:0]             secValid,
  input  logic [DB_SLOTS-1:0][DATA_W-1:0] secData,
  output dpStrobe_t                       strb,
  output logic [RD_W-1:0]                 rdData,
  output logic [LINES-1:0]                intReq
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam int DB_W  = (DB_SLOTS > 1) ? $clog2(DB_SLOTS) : 1;

  logic [CNT_W-1:0]            rstCnt;
  logic                        busy;
  logic [LINES-1:0]            intEn;
  logic [DB_SLOTS-1:0]         dbMask;
  logic [LINES-1:0][SLOTS-1:0] lineMask;
  logic [LINES-1:0]            intFlag;
  logic [LINES-1:0]            intOvf;
  logic [SLOTS-1:0]            evOvf;
  logic [LINES-1:0]            setVec;
  logic [LINES-1:0]            flagClr;
  logic [LINES-1:0]            iovClr;
  logic                        wrCtrl;
  logic                        wrStat1;
  logic                        wrEv;
  logic                        unusedWr;

  assign unusedWr = ^wrData;
  assign busy     = (rstCnt != '0);
  assign wrCtrl   = wrEn && (wrAddr == ADDR_W'(ADR_CTRL));
  assign wrStat1  = wrEn && (wrAddr == ADDR_W'(ADR_STAT1));
  assign wrEv     = wrEn && (wrAddr == ADDR_W'(ADR_EVOVF));

  // strobes toward the datapath
  always_comb begin
    strb         = '0;
    strb.eocWe   = eocIn && !busy;
    strb.eocSlot = eocSlotIn;
    strb.eocData = eocDataIn;
    strb.clrAll  = busy;
    strb.dbEn    = dbMask;
    for (int s = 0; s < SLOTS; s++)
      strb.rdPri[s] = rdEn && (rdAddr == ADDR_W'(s));
    for (int d = 0; d < DB_SLOTS; d++)
      strb.rdSec[d] = rdEn && (rdAddr == ADDR_W'(ADR_SEC + d));
  end

  for (genvar n = 0; n < LINES; n++) begin : gLine
    assign setVec[n]  = strb.eocWe && lineMask[n][eocSlotIn];
    assign flagClr[n] = wrStat1 && wrData[n];
    assign iovClr[n]  = wrStat1 && wrData[ST1_IOVF + n];
    assign intReq[n]  = intFlag[n] && intEn[n];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lineMask[n] <= '0;
      else if (wrEn && (wrAddr == ADDR_W'(ADR_MASK + n)))
        lineMask[n] <= wrData[SLOTS-1:0];
    end

    AST_REFLAG_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
      (intFlag[n] && !busy && eocIn && lineMask[n][eocSlotIn]) |=> intOvf[n]); // R9
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
      (wrStat1 && wrData[n] && !(eocIn && lineMask[n][eocSlotIn])) |=> !intFlag[n]); // R7
    AST_ROUTE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (eocIn && !busy && lineMask[n][eocSlotIn]) |=> intFlag[n]); // R7
  end

  // soft reset, control, two-deep mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
      intEn  <= '0;
      dbMask <= '0;
    end else begin
      if (wrCtrl && wrData[CTRL_RST])
        rstCnt <= CNT_W'(RST_CYCLES);
      else if (busy)
        rstCnt <= rstCnt - 1'b1;
      if (wrCtrl)
        intEn <= wrData[CTRL_EN +: LINES];
      if (wrEn && (wrAddr == ADDR_W'(ADR_DBM)))
        dbMask <= wrData[DB_SLOTS-1:0];
    end
  end

  // flags and sticky overrun bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag <= '0;
      intOvf  <= '0;
      evOvf   <= '0;
    end else if (busy) begin
      intFlag <= '0;
      intOvf  <= '0;
      evOvf   <= '0;
    end else begin
      intFlag <= setVec | (intFlag & ~flagClr);
      intOvf  <= (setVec & intFlag) | (intOvf & ~iovClr);
      evOvf   <= trgOvf | (evOvf & ~(wrEv ? wrData[SLOTS-1:0] : '0));
    end
  end

  // read mux
  logic [ADDR_W-1:0] secOff;
  logic [DB_W-1:0]   secIdx;
  logic [SLOT_W-1:0] priIdx;
  assign secOff = rdAddr - ADDR_W'(ADR_SEC);
  assign secIdx = secOff[DB_W-1:0];
  assign priIdx = rdAddr[SLOT_W-1:0];

  always_comb begin
    rdData = '0;
    if (int'(rdAddr) < SLOTS) begin
      rdData[DATA_W-1:0] = priData[priIdx];
      rdData[DATA_W]     = ovf[priIdx];
      rdData[DATA_W+1]   = priValid[priIdx];
    end else if (int'(rdAddr) < ADR_SEC + DB_SLOTS) begin
      rdData[DATA_W-1:0] = secData[secIdx];
      rdData[DATA_W]     = ovf[secIdx];
      rdData[DATA_W+1]   = secValid[secIdx];
    end else if (rdAddr == ADDR_W'(ADR_STAT0)) begin
      rdData = {ovf, priValid};
    end else if (rdAddr == ADDR_W'(ADR_STAT1)) begin
      rdData[LINES-1:0]             = intFlag;
      rdData[ST1_IOVF +: LINES]     = intOvf;
      rdData[ST1_ANYIO]             = |intOvf;
      rdData[ST1_ANYEV]             = |evOvf;
      rdData[ST1_ANYV]              = (|priValid) || (|secValid);
      rdData[ST1_ANYOV]             = |ovf;
    end else if (rdAddr == ADDR_W'(ADR_CTRL)) begin
      rdData[CTRL_RST]              = busy;
      rdData[CTRL_EN +: LINES]      = intEn;
    end else if (rdAddr == ADDR_W'(ADR_DBM)) begin
      rdData[DB_SLOTS-1:0]          = dbMask;
    end else if (int'(rdAddr) >= ADR_MASK && int'(rdAddr) < ADR_MASK + LINES) begin
      rdData[SLOTS-1:0]             = lineMask[rdAddr - ADDR_W'(ADR_MASK)];
    end else if (rdAddr == ADDR_W'(ADR_EVOVF)) begin
      rdData[SLOTS-1:0]             = evOvf;
    end
  end

  AST_RESET_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (intFlag == '0 && intOvf == '0 && evOvf == '0)); // R12
  AST_RESET_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrCtrl) |=> (rstCnt < $past(rstCnt))); // R12
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (trgOvf != '0)) |=> ((evOvf & $past(trgOvf)) == $past(trgOvf))); // R11

endmodule

// File: rtl/eocres_top.sv
module eocres_top
  import eocres_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        eocValid,
  input  logic [3:0]  eocSlot,
  input  logic [15:0] eocData,
  input  logic [15:0] trgOvf,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  input  logic [4:0]  rdAddr,
  output logic [31:0] rdData,
  output logic [3:0]  intReq
);

  dpStrobe_t                       strb;
  logic [SLOTS-1:0]                priValid;
  logic [SLOTS-1:0]                ovf;
  logic [SLOTS-1:0][DATA_W-1:0]    priData;
  logic [DB_SLOTS-1:0]             secValid;
  logic [DB_SLOTS-1:0][DATA_W-1:0] secData;

  eocres_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .eocIn     (eocValid),
    .eocSlotIn (eocSlot),
    .eocDataIn (eocData),
    .trgOvf    (trgOvf),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .priValid  (priValid),
    .ovf       (ovf),
    .priData   (priData),
    .secValid  (secValid),
    .secData   (secData),
    .strb      (strb),
    .rdData    (rdData),
    .intReq    (intReq)
  );

  eocres_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .priValid (priValid),
    .ovf      (ovf),
    .priData  (priData),
    .secValid (secValid),
    .secData  (secData)
  );

endmodule

// File: tb/eocres_tb.sv
module eocres_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eocValid = 1'b0;
  logic [3:0]  eocSlot = '0;
  logic [15:0] eocData = '0;
  logic [15:0] trgOvf = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  intReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  eocres_top dut_i (.*);

  always #5 clk = ~clk;

  // {kind 2, slot 4, data 16, expected word 18}; kind 0 completion, 1 read, 2 look
  localparam logic [39:0] VEC [8] = '{
    {2'd0, 4'd5, 16'h1234, 18'h21234},  // R1
    {2'd0, 4'd5, 16'hABCD, 18'h3ABCD},  // R2 overrun
    {2'd1, 4'd5, 16'h0000, 18'h3ABCD},  // R3 read returns old word
    {2'd0, 4'd6, 16'h0FFF, 18'h20FFF},  // R1
    {2'd1, 4'd6, 16'h0000, 18'h20FFF},  // R3
    {2'd2, 4'd6, 16'h0000, 18'h00FFF},  // R3 valid cleared, data kept
    {2'd2, 4'd5, 16'h0000, 18'h0ABCD},  // R3 overrun cleared
    {2'd0, 4'd5, 16'h0001, 18'h20001}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doEoc(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    eocValid = 1'b1; eocSlot = s; eocData = d;
    @(negedge clk);
    eocValid = 1'b0;
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state (R12)
    peek(5'd20, v); check("R12 reset stat0", v, 32'h0);
    peek(5'd21, v); check("R12 reset stat1", v, 32'h0);
    peek(5'd22, v); check("R12 reset ctrl", v, 32'h0);
    check("R8 reset intReq", {28'h0, intReq}, 32'h0);

    // table walk (R1, R2, R3)
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  k;
      logic [3:0]  s;
      logic [15:0] d;
      logic [17:0] e;
      {k, s, d, e} = VEC[i];
      if (k == 2'd0) begin
        doEoc(s, d);
        peek({1'b0, s}, v);
        check("R1 table completion", v, {14'h0, e});
      end else if (k == 2'd1) begin
        doRead({1'b0, s}, v);
        check("R3 table read", v, {14'h0, e});
      end else begin
        peek({1'b0, s}, v);
        check("R3 table look", v, {14'h0, e});
      end
    end

    peek(5'd20, v); check("R6 stat0 valid", v, 32'h0000_0020);
    peek(5'd21, v); check("R10 any valid", v, 32'h0400_0000);

    // R5: upper mask bits ignored
    doWrite(5'd23, 16'hFFFF);
    peek(5'd23, v); check("R5 mask readback", v, 32'h0000_000F);
    doEoc(4'd9, 16'h0011);
    doEoc(4'd9, 16'h0022);
    peek(5'd9, v); check("R5 slot9 single", v, 32'h0003_0022);
    peek(5'd20, v); check("R6 stat0 ov", v, 32'h0200_0220);
    peek(5'd21, v); check("R10 any ov", v, 32'h0C00_0000);
    doRead(5'd9, v);
    doRead(5'd5, v);

    // R4: two-deep slot 2
    doEoc(4'd2, 16'h000A);
    peek(5'd2, v);  check("R4 first", v, 32'h0002_000A);
    peek(5'd18, v); check("R4 second empty", v, 32'h0000_0000);
    doEoc(4'd2, 16'h000B);
    peek(5'd2, v);  check("R4 first kept", v, 32'h0002_000A);
    peek(5'd18, v); check("R4 second filled", v, 32'h0002_000B);
    doEoc(4'd2, 16'h000C);
    peek(5'd2, v);  check("R4 both full overrun", v, 32'h0003_000C);
    doRead(5'd18, v); check("R4 second read", v, 32'h0003_000B);
    peek(5'd18, v); check("R4 second cleared", v, 32'h0001_000B);
    doRead(5'd2, v); check("R4 first read", v, 32'h0003_000C);
    peek(5'd2, v);  check("R4 first cleared", v, 32'h0000_000C);
    doWrite(5'd23, 16'h0000);
    doEoc(4'd2, 16'h000D);
    doEoc(4'd2, 16'h000E);
    peek(5'd2, v);  check("R4 disabled overrun", v, 32'h0003_000E);
    doRead(5'd2, v);

    // R7/R8/R9 interrupt routing
    doWrite(5'd25, 16'h0080);
    doWrite(5'd22, 16'h0008);
    doEoc(4'd7, 16'h0077);
    peek(5'd21, v); check("R7 flag1 set", v, 32'h0400_0002);
    check("R8 intReq on", {28'h0, intReq}, 32'h2);
    doEoc(4'd7, 16'h0078);
    peek(5'd21, v); check("R9 int overrun", v, 32'h0D00_0202);
    doWrite(5'd21, 16'h0202);
    peek(5'd21, v); check("R7 W1C", v, 32'h0C00_0000);
    check("R8 intReq off", {28'h0, intReq}, 32'h0);
    doWrite(5'd22, 16'h0000);
    doEoc(4'd7, 16'h0079);
    peek(5'd21, v); check("R7 flag without enable", v[3:0], 32'h2);
    check("R8 disabled no request", {28'h0, intReq}, 32'h0);
    doWrite(5'd21, 16'h0302);
    doRead(5'd7, v);

    // R11 trigger overrun
    @(negedge clk); trgOvf = 16'h0008;
    @(negedge clk); trgOvf = 16'h0000;
    peek(5'd28, v); check("R11 trig sticky", v, 32'h0000_0008);
    peek(5'd21, v); check("R10 any trig ovf", v, 32'h0200_0000);
    doWrite(5'd28, 16'h0008);
    peek(5'd28, v); check("R11 trig W1C", v, 32'h0);

    // R13 read and completion together
    doEoc(4'd4, 16'h0044);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 5'd4; eocValid = 1'b1; eocSlot = 4'd4; eocData = 16'h0055;
    #1 v = rdData;
    check("R13 old word", v, 32'h0002_0044);
    @(negedge clk);
    rdEn = 1'b0; eocValid = 1'b0;
    peek(5'd4, v); check("R13 new valid no ov", v, 32'h0002_0055);
    doRead(5'd4, v);

    // R12 soft reset
    doWrite(5'd25, 16'h0008);
    doEoc(4'd3, 16'h0033);
    @(negedge clk); trgOvf = 16'h0001;
    @(negedge clk); trgOvf = 16'h0000;
    doWrite(5'd22, 16'h000A);
    peek(5'd22, v); check("R12 busy bit", v, 32'h0000_000A);
    peek(5'd21, v); check("R12 stat1 cleared", v, 32'h0);
    doEoc(4'd3, 16'h0099);
    repeat (4) @(negedge clk);
    peek(5'd22, v); check("R12 self clear", v, 32'h0000_0008);
    peek(5'd3, v);  check("R12 data kept, completion ignored", v, 32'h0000_0033);
    peek(5'd20, v); check("R12 stat0 cleared", v, 32'h0);
    peek(5'd25, v); check("R12 mask kept", v, 32'h0000_0008);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule